// File: doc/BRIEF.md
# Datapath Flush Sequencer

This block sequences the clearing of an interpolating transmit datapath that ends in CIC interpolation stages. While a flush runs, the incoming I and Q sample words are blocked and zeros go out on both lanes. A CIC reset line is held high for a number of cycles equal to the programmed interpolation rate times a fixed pipeline depth. One cycle later a single-cycle completion pulse is raised. Four sources start a flush: release of the master reset, a software flush bit that clears itself, a return of PLL lock (only when lock supervision is enabled), and a rising power-down or sleep request.

The sequencer keeps a one-hot state in four states: IDLE, WAIT_LOCK, FLUSH and DONE. The transitions are:
- IDLE to FLUSH when any flush request is pending.
- IDLE to WAIT_LOCK when lock supervision is enabled and the PLL reports loss of lock.
- WAIT_LOCK to FLUSH once lock returns.
- WAIT_LOCK to IDLE if supervision is switched off while waiting.
- FLUSH to DONE when the length counter reaches zero.
- DONE to IDLE unconditionally.

The flush length is computed and loaded when FLUSH is entered. After a power-down or sleep request has been served by a complete flush, a clock-stop permission output is raised for the power controller.

Top module: `dfs_flush_seq`

## Requirements
- R1: After master reset (active high, asynchronous), the outputs are: lock supervision disable bit `lock_ignore` = 1, `soft_flush` = 0, `done` = 0, `cic_rst` = 0. Releasing master reset starts a flush with no other request.
- R2: A flush keeps `cic_rst` high for exactly max(rate,1) × DEPTH consecutive cycles, where rate is the `interp_rate` value sampled when the flush starts. A rate value of 0 counts as 1.
- R3: While `cic_rst` is high, `path_i` and `path_q` are zero whatever `smp_i` and `smp_q` carry. Otherwise they equal `smp_i` and `smp_q`.
- R4: The state is one-hot over IDLE, WAIT_LOCK, FLUSH and DONE. `done` is high for exactly one cycle, in the cycle right after the last `cic_rst` cycle.
- R5: A one-cycle `soft_flush_wr` strobe sets `soft_flush` in the next cycle and starts a flush. `soft_flush` returns to 0 by itself when the flush completes.
- R6: Any request raised while a flush runs is absorbed. This includes a new soft write and a change of `interp_rate`. The running flush keeps its length and no second flush follows.
- R7: With `lock_ignore` = 1, a low `pll_locked` never starts a flush.
- R8: With `lock_ignore` = 0, a low `pll_locked` starts no flush while lock stays lost. A flush starts once `pll_locked` returns high.
- R9: A rising `pdn_req` or `sleep_req` starts a flush. `clk_stop_ok` is 0 before and during that flush, becomes 1 after completion while the request is held, and falls to 0 as soon as both requests are low.
- R10: Writing `lock_ignore` = 1 while waiting for lock returns the sequencer to IDLE, and the later return of lock starts no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| mrst | input | 1 | Master reset, active high, asynchronous |
| soft_flush_wr | input | 1 | Strobe writing 1 to the self-clearing flush bit |
| lock_wr | input | 1 | Write strobe for the lock supervision bit |
| lock_din | input | 1 | Value written to `lock_ignore` |
| pll_locked | input | 1 | PLL lock indicator |
| pdn_req | input | 1 | Digital power-down request (level) |
| sleep_req | input | 1 | Full sleep request (level) |
| interp_rate | input | RATE_W | Programmed overall interpolation rate |
| smp_i | input | DW | Incoming I sample |
| smp_q | input | DW | Incoming Q sample |
| path_i | output | DW | I sample into the filter chain |
| path_q | output | DW | Q sample into the filter chain |
| cic_rst | output | 1 | Holds CIC memory elements in reset |
| done | output | 1 | One-cycle flush completion pulse |
| soft_flush | output | 1 | Readback of the self-clearing flush bit |
| lock_ignore | output | 1 | Readback of the lock supervision bit (1 = lock loss ignored) |
| clk_stop_ok | output | 1 | Power-down or sleep may stop clocks |

## Verification
The hardest situation to reach is the WAIT_LOCK state and both of its exits. Reaching it takes a write that clears `lock_ignore`, followed by a long window with `pll_locked` held low, during which the bench confirms that no flush begins. One exit is taken by restoring lock, which must produce a flush of the expected length. The other is taken by setting `lock_ignore` again before lock returns, which must produce none. A second hard case is a soft write plus a rate change injected in the middle of a running flush. Near-exhaustive sweeps cover every rate value of a small configuration, and each flush length is compared with a product computed in the bench.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'b0001,
        ST_WAIT_LOCK = 4'b0010,
        ST_FLUSH     = 4'b0100,
        ST_DONE      = 4'b1000
    } dfs_state_e;

    localparam int LANES = 2;

endpackage

// File: rtl/dfs_req_track.sv
module dfs_req_track (
    input  logic clk,
    input  logic mrst,
    input  logic soft_flush_wr,
    input  logic lock_wr,
    input  logic lock_din,
    input  logic pdn_req,
    input  logic sleep_req,
    input  logic flush_end,
    output logic any_pend,
    output logic soft_bit,
    output logic lock_ign,
    output logic pd_any,
    output logic pwr_served
);

    logic pend_rst;
    logic pend_soft;
    logic pend_pwr;
    logic pd_prev;
    logic pd_rise;

    assign pd_any  = pdn_req | sleep_req;
    assign pd_rise = pd_any & ~pd_prev;

    // reset release itself is a pending request
    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) begin
            pend_rst  <= 1'b1;
            pend_soft <= 1'b0;
            pend_pwr  <= 1'b0;
            pd_prev   <= 1'b0;
        end else begin
            pd_prev <= pd_any;
            if (flush_end) begin
                pend_rst  <= 1'b0;
                pend_soft <= 1'b0;
                pend_pwr  <= 1'b0;
            end else begin
                if (soft_flush_wr) pend_soft <= 1'b1;
                if (pd_rise)       pend_pwr  <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) begin
            lock_ign <= 1'b1;
        end else if (lock_wr) begin
            lock_ign <= lock_din;
        end
    end

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) begin
            pwr_served <= 1'b0;
        end else if (!pd_any) begin
            pwr_served <= 1'b0;
        end else if (flush_end) begin
            pwr_served <= 1'b1;
        end
    end

    assign any_pend = pend_rst | pend_soft | pend_pwr;
    assign soft_bit = pend_soft;

endmodule

// File: rtl/dfs_len_timer.sv
module dfs_len_timer #(
    parameter int RATE_W = 6,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              load,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              last
);

    localparam int CNT_W = RATE_W + $clog2(DEPTH) + 1;

    logic [CNT_W-1:0] rate_eff;
    logic [CNT_W-1:0] len_m1;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        rate_eff = (rate == '0) ? CNT_W'(1) : CNT_W'(rate);
        len_m1   = rate_eff * CNT_W'(DEPTH) - CNT_W'(1);
    end

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len_m1;
        end else if (run && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign last = (cnt == '0);

endmodule

// File: rtl/dfs_lane_gate.sv
module dfs_lane_gate #(
    parameter int DW = 14
) (
    input  logic          zero,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    always_comb begin
        dout = zero ? '0 : din;
    end

endmodule

// File: rtl/dfs_flush_seq.sv
module dfs_flush_seq
    import dfs_pkg::*;
#(
    parameter int DW     = 14,
    parameter int RATE_W = 6,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              soft_flush_wr,
    input  logic              lock_wr,
    input  logic              lock_din,
    input  logic              pll_locked,
    input  logic              pdn_req,
    input  logic              sleep_req,
    input  logic [RATE_W-1:0] interp_rate,
    input  logic [DW-1:0]     smp_i,
    input  logic [DW-1:0]     smp_q,
    output logic [DW-1:0]     path_i,
    output logic [DW-1:0]     path_q,
    output logic              cic_rst,
    output logic              done,
    output logic              soft_flush,
    output logic              lock_ignore,
    output logic              clk_stop_ok
);

    dfs_state_e state_q;
    dfs_state_e state_d;

    logic any_pend;
    logic pd_any;
    logic pwr_served;
    logic cnt_last;
    logic in_flush;
    logic flush_load;
    logic flush_end;

    logic [LANES-1:0][DW-1:0] lane_in;
    logic [LANES-1:0][DW-1:0] lane_out;

    dfs_req_track req_i (
        .clk           (clk),
        .mrst          (mrst),
        .soft_flush_wr (soft_flush_wr),
        .lock_wr       (lock_wr),
        .lock_din      (lock_din),
        .pdn_req       (pdn_req),
        .sleep_req     (sleep_req),
        .flush_end     (flush_end),
        .any_pend      (any_pend),
        .soft_bit      (soft_flush),
        .lock_ign      (lock_ignore),
        .pd_any        (pd_any),
        .pwr_served    (pwr_served)
    );

    dfs_len_timer #(
        .RATE_W (RATE_W),
        .DEPTH  (DEPTH)
    ) tmr_i (
        .clk  (clk),
        .mrst (mrst),
        .load (flush_load),
        .run  (in_flush),
        .rate (interp_rate),
        .last (cnt_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_pend) begin
                    state_d = ST_FLUSH;
                end else if (!lock_ignore && !pll_locked) begin
                    state_d = ST_WAIT_LOCK;
                end
            end
            ST_WAIT_LOCK: begin
                if (lock_ignore) begin
                    state_d = ST_IDLE;
                end else if (pll_locked) begin
                    state_d = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (cnt_last) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from state
    always_comb begin
        in_flush   = (state_q == ST_FLUSH);
        flush_end  = (state_q == ST_DONE);
        flush_load = (state_d == ST_FLUSH) && (state_q != ST_FLUSH);
        cic_rst    = in_flush;
        done       = flush_end;
        clk_stop_ok = pwr_served & pd_any & ~in_flush;
    end

    assign lane_in[0] = smp_i;
    assign lane_in[1] = smp_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dfs_lane_gate #(.DW(DW)) gate_i (
            .zero (in_flush),
            .din  (lane_in[g]),
            .dout (lane_out[g])
        );
    end

    assign path_i = lane_out[0];
    assign path_q = lane_out[1];

endmodule

// File: rtl/dfs_flush_seq_chk.sv
module dfs_flush_seq_chk #(
    parameter int DW = 14
) (
    input logic          clk,
    input logic          mrst,
    input logic [3:0]    state,
    input logic [DW-1:0] path_i,
    input logic [DW-1:0] path_q,
    input logic          cic_rst,
    input logic          done,
    input logic          soft_flush,
    input logic          clk_stop_ok
);

    p_state_onehot_r4: assert property (@(posedge clk) disable iff (mrst)
        $onehot(state));

    p_done_single_r4: assert property (@(posedge clk) disable iff (mrst)
        done |=> !done);

    p_done_after_flush_r4: assert property (@(posedge clk) disable iff (mrst)
        done |-> $past(cic_rst));

    p_zero_lanes_r3: assert property (@(posedge clk) disable iff (mrst)
        cic_rst |-> (path_i == '0 && path_q == '0));

    p_soft_self_clear_r5: assert property (@(posedge clk) disable iff (mrst)
        done |=> !soft_flush);

    p_no_stop_in_flush_r9: assert property (@(posedge clk) disable iff (mrst)
        clk_stop_ok |-> !cic_rst);

endmodule

bind dfs_flush_seq dfs_flush_seq_chk #(.DW(DW)) chk_i (
    .clk         (clk),
    .mrst        (mrst),
    .state       (state_q),
    .path_i      (path_i),
    .path_q      (path_q),
    .cic_rst     (cic_rst),
    .done        (done),
    .soft_flush  (soft_flush),
    .clk_stop_ok (clk_stop_ok)
);

// File: tb/dfs_flush_seq_tb.sv
module dfs_flush_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW     = 14;
    localparam int RATE_W = 3;
    localparam int DEPTH  = 4;

    logic              clk = 1'b0;
    logic              mrst;
    logic              soft_flush_wr;
    logic              lock_wr;
    logic              lock_din;
    logic              pll_locked;
    logic              pdn_req;
    logic              sleep_req;
    logic [RATE_W-1:0] interp_rate;
    logic [DW-1:0]     smp_i;
    logic [DW-1:0]     smp_q;
    logic [DW-1:0]     path_i;
    logic [DW-1:0]     path_q;
    logic              cic_rst;
    logic              done;
    logic              soft_flush;
    logic              lock_ignore;
    logic              clk_stop_ok;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dfs_flush_seq #(.DW(DW), .RATE_W(RATE_W), .DEPTH(DEPTH)) dut_i (
        .clk           (clk),
        .mrst          (mrst),
        .soft_flush_wr (soft_flush_wr),
        .lock_wr       (lock_wr),
        .lock_din      (lock_din),
        .pll_locked    (pll_locked),
        .pdn_req       (pdn_req),
        .sleep_req     (sleep_req),
        .interp_rate   (interp_rate),
        .smp_i         (smp_i),
        .smp_q         (smp_q),
        .path_i        (path_i),
        .path_q        (path_q),
        .cic_rst       (cic_rst),
        .done          (done),
        .soft_flush    (soft_flush),
        .lock_ignore   (lock_ignore),
        .clk_stop_ok   (clk_stop_ok)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input int r);
        return ((r == 0) ? 1 : r) * DEPTH;
    endfunction

    // Waits for a flush, measures it, checks zeroing, done pulse and stop permission.
    // inject_at >= 0: at that flush cycle pulse a soft write and change the rate (R6).
    task automatic measure(input int exp, input string tag, input int inject_at);
        int  n = 0;
        bit  seen = 0;
        bit  zero_ok = 1;
        bit  stop_ok = 1;
        for (int w = 0; w < 300 && !seen; w++) begin
            @(negedge clk);
            if (cic_rst) seen = 1;
        end
        check(seen, {tag, " flush start"}, seen, 1);
        while (cic_rst) begin
            if (path_i != '0 || path_q != '0) zero_ok = 0;
            if (clk_stop_ok) stop_ok = 0;
            if (n == inject_at) begin
                soft_flush_wr = 1'b1;
                interp_rate   = 3'd7;
            end else begin
                soft_flush_wr = 1'b0;
            end
            n++;
            @(negedge clk);
            if (n > 200) break;
        end
        soft_flush_wr = 1'b0;
        check(n == exp, {tag, " R2 flush length"}, n, exp);
        check(zero_ok, "R3 lanes zero during flush", zero_ok, 1);
        check(stop_ok, "R9 no clock stop during flush", stop_ok, 1);
        check(done == 1'b1, {tag, " R4 done after last flush cycle"}, done, 1);
        @(negedge clk);
        check(done == 1'b0, {tag, " R4 done single cycle"}, done, 0);
    endtask

    task automatic quiet(input int cycles, input string tag);
        bit q = 1;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (cic_rst) q = 0;
        end
        check(q, tag, q, 1);
    endtask

    task automatic soft_write();
        soft_flush_wr = 1'b1;
        @(negedge clk);
        soft_flush_wr = 1'b0;
    endtask

    task automatic lock_write(input logic v);
        lock_din = v;
        lock_wr  = 1'b1;
        @(negedge clk);
        lock_wr  = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        mrst          = 1'b1;
        soft_flush_wr = 1'b0;
        lock_wr       = 1'b0;
        lock_din      = 1'b0;
        pll_locked    = 1'b1;
        pdn_req       = 1'b0;
        sleep_req     = 1'b0;
        interp_rate   = 3'd3;
        smp_i         = 14'h1234;
        smp_q         = 14'h2abc;

        // R1 reset values
        repeat (6) @(negedge clk);
        check(lock_ignore == 1'b1, "R1 lock_ignore reset", lock_ignore, 1);
        check(soft_flush == 1'b0, "R1 soft_flush reset", soft_flush, 0);
        check(done == 1'b0, "R1 done reset", done, 0);
        check(cic_rst == 1'b0, "R1 cic_rst reset", cic_rst, 0);
        mrst = 1'b0;
        measure(exp_len(3), "R1 reset release", -1);
        check(soft_flush == 1'b0, "R1 soft bit stays clear", soft_flush, 0);

        // R2 / R5 sweep of every rate via soft write, R3 passthrough
        for (int r = 0; r < (1 << RATE_W); r++) begin
            interp_rate = RATE_W'(r);
            smp_i = DW'(r * 97 + 5);
            smp_q = DW'(r * 311 + 9);
            @(negedge clk);
            check(path_i == DW'(r * 97 + 5), "R3 I passthrough", int'(path_i), r * 97 + 5);
            check(path_q == DW'(r * 311 + 9), "R3 Q passthrough", int'(path_q), r * 311 + 9);
            soft_write();
            check(soft_flush == 1'b1, "R5 soft bit set", soft_flush, 1);
            measure(exp_len(r), "R5 soft", -1);
            check(soft_flush == 1'b0, "R5 soft bit self clear", soft_flush, 0);
        end

        // R6 requests and rate change during a flush are absorbed
        interp_rate = 3'd2;
        soft_write();
        measure(exp_len(2), "R6 absorbed", 3);
        quiet(40, "R6 no second flush");

        // R7 lock loss ignored when supervision off
        pll_locked = 1'b0;
        quiet(40, "R7 no flush on lock loss");
        pll_locked = 1'b1;
        quiet(5, "R7 no flush on lock return");

        // R8 supervision on: wait then flush on lock return
        interp_rate = 3'd5;
        lock_write(1'b0);
        check(lock_ignore == 1'b0, "R8 lock_ignore written", lock_ignore, 0);
        pll_locked = 1'b0;
        quiet(50, "R8 no flush while unlocked");
        pll_locked = 1'b1;
        measure(exp_len(5), "R8 lock regained", -1);

        // R10 cancel the wait
        pll_locked = 1'b0;
        quiet(10, "R10 waiting");
        lock_write(1'b1);
        quiet(5, "R10 cancelled");
        pll_locked = 1'b1;
        quiet(40, "R10 no flush after cancel");

        // R9 power-down and sleep
        interp_rate = 3'd4;
        check(clk_stop_ok == 1'b0, "R9 stop low idle", clk_stop_ok, 0);
        pdn_req = 1'b1;
        measure(exp_len(4), "R9 power-down", -1);
        check(clk_stop_ok == 1'b1, "R9 stop after pdn flush", clk_stop_ok, 1);
        pdn_req = 1'b0;
        @(negedge clk);
        check(clk_stop_ok == 1'b0, "R9 stop drops with pdn", clk_stop_ok, 0);
        interp_rate = 3'd1;
        sleep_req = 1'b1;
        measure(exp_len(1), "R9 sleep", -1);
        check(clk_stop_ok == 1'b1, "R9 stop after sleep flush", clk_stop_ok, 1);
        sleep_req = 1'b0;
        @(negedge clk);
        check(clk_stop_ok == 1'b0, "R9 stop drops with sleep", clk_stop_ok, 0);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule